// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor port and a main memory port that moves one word per beat. It works on 16-bit word addresses and keeps 128 lines of 16 words. For each line it holds a tag, a valid flag and a dirty flag. A hit is answered from the local store without any memory traffic. A miss picks a victim. If the victim holds modified data, the whole victim block is copied back first, and then the requested block is fetched one word per beat. Writes follow a write-back, write-allocate policy.

The processor side uses a request/ready handshake. A request is taken in a cycle where both `cpu_req` and `cpu_ready` are high. Reads answer with a one-cycle `cpu_rvalid` pulse. `cpu_ready` stays low while any block transfer or flush is under way. A separate invalidate input lets an agent that changed memory directly remove a stale resident copy. A flush input writes back every modified line without evicting any of them. The parameter `EARLY_RESTART` lets a read miss hand its word to the processor as soon as that beat arrives.

Top module: `dmc_cache`

## Requirements
- R1: The word address splits into offset = bits [3:0], line index = bits [10:4] and tag = bits [15:11]. A block can only occupy the line its index selects, and a new block replaces whatever that line held.
- R2: After reset every line is invalid, `cpu_ready` is 1, and `mem_req` and `cpu_rvalid` are 0.
- R3: A read miss fetches all 16 words of the block with `mem_we`=0, in ascending offset order from offset 0, one word per cycle with `mem_ack` high. `mem_addr` and `mem_we` stay unchanged while `mem_ack` is low. The requested word is then returned on `cpu_rdata`.
- R4: A read hit raises `cpu_rvalid` with the stored word in the cycle after acceptance and makes no memory request.
- R5: A write hit changes only the cached word, makes no memory request, and marks the line modified. A modified line is always valid.
- R6: A write miss first fetches the whole block, then overwrites the addressed word in the cache. Memory is not written at that point.
- R7: When a miss replaces a modified line, all 16 words of the old block are first written to memory (`mem_we`=1) at the old tag's addresses in ascending offset order, before any fetch. Replacing an unmodified line writes nothing.
- R8: A one-cycle `inv_en` pulse whose `inv_addr` falls in a resident block clears that line's valid and modified flags. Any modified data there is discarded, and the next access to the block fetches it from memory. An `inv_addr` whose block is not resident changes nothing.
- R9: With `EARLY_RESTART`=1 (the default), a read miss raises `cpu_rvalid` in the cycle after the beat that carries the requested word, while `cpu_ready` is still low. With 0, it is raised only after the whole block has arrived.
- R10: `cpu_ready` is 0 whenever a writeback, refill or flush is in progress, and no request is accepted during that time.
- R11: A `flush_req` pulse taken while the block is idle visits lines 0 to 127 in order. Every valid modified line is written back as 16 words, and its modified flag is then cleared so that a later replacement writes nothing. Unmodified lines cause no traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 16 | Read data |
| flush_req | input | 1 | Start a write-back of all modified lines |
| inv_en | input | 1 | Invalidate strobe from an external memory writer |
| inv_addr | input | 16 | Word address updated behind the cache |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory accepts/returns the current beat |
| mem_rdata | input | 16 | Memory read data |

## Verification
The hardest state to reach from the ports is a miss whose victim line is both valid and modified. To get there, the processor must first fill a line, then write into it, and then touch a different tag that maps to the same index. Only after that sequence does the copy-back happen ahead of the fetch. The directed part of the bench builds this sequence on index 0x12 using tags 0 and 1, and repeats it with an invalidation in the middle and with a flush in place of the eviction. The seeded random phase then restricts addresses to three indices and four tags, so conflicting tags collide on the same lines again and again. Memory acknowledges at random, which stretches each beat by a varying number of cycles.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_REFILL,
    ST_FINISH,
    ST_SCAN,
    ST_FLUSHWB
  } ctl_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];
  logic             inv_hit;

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  always_comb begin
    inv_hit = inv_en && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag) &&
              !(fill_en && (fill_idx == inv_idx));
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      dirty_d[fill_idx] = 1'b0;
    end
    if (dirty_set) dirty_d[upd_idx] = 1'b1;
    if (dirty_clr) dirty_d[upd_idx] = 1'b0;
    if (inv_hit) begin
      valid_d[inv_idx] = 1'b0;
      dirty_d[inv_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  // R5: a modified line is always a valid line
  a_r5_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);

  // R8: a resident block hit by an invalidate is gone one cycle later
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag) &&
    !(fill_en && (fill_idx == inv_idx))
    |=> !valid_q[$past(inv_idx)]);

  // R3: completing a block fetch leaves the line valid and unmodified
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int ADDR_W = 11,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] word_q [DEPTH];

  assign rdata = word_q[raddr];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int OFF_W         = 4,
  parameter int IDX_W         = 7,
  parameter int TAG_W         = 5,
  parameter bit EARLY_RESTART = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [AW-1:0]          cpu_addr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   cpu_ready,
  output logic                   cpu_rvalid,
  output logic [DW-1:0]          cpu_rdata,
  input  logic                   flush_req,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata,
  output logic [IDX_W-1:0]       rd_idx,
  input  logic                   rd_valid,
  input  logic                   rd_dirty,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic                   fill_en,
  output logic [IDX_W-1:0]       fill_idx,
  output logic [TAG_W-1:0]       fill_tag,
  output logic                   dirty_set,
  output logic                   dirty_clr,
  output logic [IDX_W-1:0]       upd_idx,
  output logic                   d_we,
  output logic [IDX_W+OFF_W-1:0] d_waddr,
  output logic [DW-1:0]          d_wdata,
  output logic [IDX_W+OFF_W-1:0] d_raddr,
  input  logic [DW-1:0]          d_rdata
);
  ctl_state_e       state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0] line_q, line_d;
  logic [TAG_W-1:0] victim_q, victim_d;
  logic [AW-1:0]    raddr_q, raddr_d;
  logic             rwe_q, rwe_d;
  logic [DW-1:0]    rwdata_q, rwdata_d;
  logic             rvalid_q, rvalid_d;
  logic [DW-1:0]    rdata_q, rdata_d;

  logic [OFF_W-1:0] c_off, r_off;
  logic [IDX_W-1:0] c_idx, r_idx;
  logic [TAG_W-1:0] c_tag, r_tag;
  logic             idle, accept, hit, beat_ack, last_beat, last_line, early_word;

  assign c_off = cpu_addr[OFF_W-1:0];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_addr[AW-1 -: TAG_W];
  assign r_off = raddr_q[OFF_W-1:0];
  assign r_idx = raddr_q[OFF_W +: IDX_W];
  assign r_tag = raddr_q[AW-1 -: TAG_W];

  assign idle      = (state_q == ST_IDLE);
  assign cpu_ready = idle && !flush_req;
  assign accept    = cpu_req && cpu_ready;
  assign hit       = rd_valid && (rd_tag == c_tag);
  assign last_beat = (beat_q == {OFF_W{1'b1}});
  assign last_line = (line_q == {IDX_W{1'b1}});

  assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_REFILL) || (state_q == ST_FLUSHWB);
  assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_FLUSHWB);
  assign mem_wdata = d_rdata;
  assign beat_ack  = mem_req && mem_ack;

  generate
    if (EARLY_RESTART) begin : g_early
      assign early_word = !rwe_q && (beat_q == r_off);
    end else begin : g_late
      assign early_word = 1'b0;
    end
  endgenerate

  always_comb begin
    case (state_q)
      ST_EVICT:   mem_addr = {victim_q, r_idx, beat_q};
      ST_FLUSHWB: mem_addr = {victim_q, line_q, beat_q};
      default:    mem_addr = {r_tag, r_idx, beat_q};
    endcase
    case (state_q)
      ST_IDLE:             rd_idx = c_idx;
      ST_SCAN, ST_FLUSHWB: rd_idx = line_q;
      default:             rd_idx = r_idx;
    endcase
    case (state_q)
      ST_IDLE:    d_raddr = {c_idx, c_off};
      ST_FINISH:  d_raddr = {r_idx, r_off};
      ST_FLUSHWB: d_raddr = {line_q, beat_q};
      default:    d_raddr = {r_idx, beat_q};
    endcase
  end

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    line_d    = line_q;
    victim_d  = victim_q;
    raddr_d   = raddr_q;
    rwe_d     = rwe_q;
    rwdata_d  = rwdata_q;
    rvalid_d  = 1'b0;
    rdata_d   = rdata_q;
    fill_en   = 1'b0;
    fill_idx  = r_idx;
    fill_tag  = r_tag;
    dirty_set = 1'b0;
    dirty_clr = 1'b0;
    upd_idx   = r_idx;
    d_we      = 1'b0;
    d_waddr   = {r_idx, beat_q};
    d_wdata   = mem_rdata;
    case (state_q)
      ST_IDLE: begin
        if (flush_req) begin
          line_d  = '0;
          state_d = ST_SCAN;
        end else if (accept) begin
          raddr_d  = cpu_addr;
          rwe_d    = cpu_we;
          rwdata_d = cpu_wdata;
          if (hit) begin
            if (cpu_we) begin
              d_we      = 1'b1;
              d_waddr   = {c_idx, c_off};
              d_wdata   = cpu_wdata;
              dirty_set = 1'b1;
              upd_idx   = c_idx;
            end else begin
              rvalid_d = 1'b1;
              rdata_d  = d_rdata;
            end
          end else begin
            victim_d = rd_tag;
            beat_d   = '0;
            state_d  = (rd_valid && rd_dirty) ? ST_EVICT : ST_REFILL;
          end
        end
      end
      ST_EVICT: begin
        if (beat_ack) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        if (beat_ack) begin
          d_we   = 1'b1;
          beat_d = beat_q + 1'b1;
          if (early_word) begin
            rvalid_d = 1'b1;
            rdata_d  = mem_rdata;
          end
          if (last_beat) begin
            fill_en = 1'b1;
            state_d = ST_FINISH;
          end
        end
      end
      ST_FINISH: begin
        if (rwe_q) begin
          d_we      = 1'b1;
          d_waddr   = {r_idx, r_off};
          d_wdata   = rwdata_q;
          dirty_set = 1'b1;
        end else if (!EARLY_RESTART) begin
          rvalid_d = 1'b1;
          rdata_d  = d_rdata;
        end
        state_d = ST_IDLE;
      end
      ST_SCAN: begin
        if (rd_valid && rd_dirty) begin
          victim_d = rd_tag;
          beat_d   = '0;
          state_d  = ST_FLUSHWB;
        end else if (last_line) begin
          state_d = ST_IDLE;
        end else begin
          line_d = line_q + 1'b1;
        end
      end
      ST_FLUSHWB: begin
        if (beat_ack) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) begin
            dirty_clr = 1'b1;
            upd_idx   = line_q;
            if (last_line) begin
              state_d = ST_IDLE;
            end else begin
              line_d  = line_q + 1'b1;
              state_d = ST_SCAN;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      line_q   <= '0;
      victim_q <= '0;
      raddr_q  <= '0;
      rwe_q    <= 1'b0;
      rwdata_q <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      line_q   <= line_d;
      victim_q <= victim_d;
      raddr_q  <= raddr_d;
      rwe_q    <= rwe_d;
      rwdata_q <= rwdata_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  // R10: no processor handshake while memory beats are outstanding
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R3: a beat waiting for acknowledge keeps its address and direction
  a_r3_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R7: within a block the offset advances by one after every acknowledged beat
  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
    |=> mem_req && (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));

  // R6: a write miss never returns read data
  a_r6_write_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_we |=> !cpu_rvalid);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int OFF_W         = 4,
  parameter int IDX_W         = 7,
  parameter bit EARLY_RESTART = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  input  logic          flush_req,
  input  logic          inv_en,
  input  logic [AW-1:0] inv_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam int LOC_W = IDX_W + OFF_W;

  logic [IDX_W-1:0] rd_idx, fill_idx, upd_idx;
  logic             rd_valid, rd_dirty, fill_en, dirty_set, dirty_clr;
  logic [TAG_W-1:0] rd_tag, fill_tag;
  logic             d_we;
  logic [LOC_W-1:0] d_waddr, d_raddr;
  logic [DW-1:0]    d_wdata, d_rdata;

  dmc_ctrl #(
    .AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .EARLY_RESTART(EARLY_RESTART)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .flush_req(flush_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr), .upd_idx(upd_idx),
    .d_we(d_we), .d_waddr(d_waddr), .d_wdata(d_wdata),
    .d_raddr(d_raddr), .d_rdata(d_rdata)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr), .upd_idx(upd_idx),
    .inv_en(inv_en), .inv_idx(inv_addr[OFF_W +: IDX_W]), .inv_tag(inv_addr[AW-1 -: TAG_W])
  );

  dmc_data_store #(.ADDR_W(LOC_W), .DW(DW)) i_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );
endmodule

// File: tb/test_dmc_cache.sv
module test_dmc_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready, cpu_rvalid;
  logic [15:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        flush_req, inv_en;
  logic [15:0] inv_addr;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_err    = 0;

  logic [15:0] mem_over [int];
  logic [15:0] cpu_ref  [int];
  logic [15:0] wr_log [$];
  logic [15:0] rd_log [$];

  dmc_cache #(.EARLY_RESTART(1'b1)) i_dmc_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .flush_req(flush_req), .inv_en(inv_en), .inv_addr(inv_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [15:0] base_val(input logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] memval(input logic [15:0] a);
    if (mem_over.exists(int'(a))) return mem_over[int'(a)];
    return base_val(a);
  endfunction

  function automatic logic [15:0] expect_val(input logic [15:0] a);
    if (cpu_ref.exists(int'(a))) return cpu_ref[int'(a)];
    return memval(a);
  endfunction

  // memory model: answers at the falling edge, commits at the rising edge
  always @(negedge clk) begin
    mem_ack   <= mem_req && ($urandom_range(3) != 0);
    mem_rdata <= memval(mem_addr);
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        mem_over[int'(mem_addr)] = mem_wdata;
        wr_log.push_back(mem_addr);
      end else begin
        rd_log.push_back(mem_addr);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_log.delete();
    rd_log.delete();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  task automatic cpu_op(input bit we, input logic [15:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int lat, output bit early);
    bit got;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    rd = '0; lat = 1; early = 1'b0; got = 1'b0;
    forever begin
      if (!we && !got && cpu_rvalid) begin
        got = 1'b1; rd = cpu_rdata; early = !cpu_ready;
      end
      if (cpu_ready && (we || got)) break;
      @(negedge clk);
      if (!got) lat++;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [15:0] rd; int lat; bit early;
    cpu_op(1'b0, a, 16'h0, rd, lat, early);
    check(tag, rd, expect_val(a));
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] wd);
    logic [15:0] rd; int lat; bit early;
    cpu_op(1'b1, a, wd, rd, lat, early);
    cpu_ref[int'(a)] = wd;
  endtask

  task automatic ext_update(input logic [15:0] a, input logic [15:0] v);
    @(negedge clk);
    mem_over[int'(a)] = v;
    for (int k = 0; k < 16; k++) cpu_ref.delete(int'({a[15:4], 4'(k)}));
    inv_en = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [15:0] rd; int lat; bit early; int bad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    flush_req = 1'b0; inv_en = 1'b0; inv_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 ready after reset", cpu_ready, 1);
    check("R2 mem_req after reset", mem_req, 0);
    check("R2 rvalid after reset", cpu_rvalid, 0);

    // R3/R9: read miss on an empty line
    clear_logs();
    cpu_op(1'b0, 16'h0123, 16'h0, rd, lat, early);
    check("R3 fill beat count", rd_log.size(), 16);
    bad = 0;
    for (int i = 0; i < rd_log.size(); i++) if (rd_log[i] != 16'h0120 + 16'(i)) bad++;
    check("R3 fill order", bad, 0);
    check("R3 read miss data", rd, base_val(16'h0123));
    check("R2 empty line needs no writeback", wr_log.size(), 0);
    check("R9 early word while busy", early, 1);
    check("R10 ready low during refill", (lat > 1), 1);

    // R4: read hit
    clear_logs();
    cpu_op(1'b0, 16'h0127, 16'h0, rd, lat, early);
    check("R4 hit latency", lat, 1);
    check("R4 hit no memory", rd_log.size() + wr_log.size(), 0);
    check("R4 hit data", rd, base_val(16'h0127));

    // R5: write hit
    clear_logs();
    do_write(16'h0125, 16'hBEEF);
    check("R5 write hit no memory", rd_log.size() + wr_log.size(), 0);
    do_read(16'h0125, "R5 write hit readback");
    check("R5 memory unchanged", memval(16'h0125), base_val(16'h0125));

    // R7/R1: conflicting tag on index 0x12 evicts the modified block
    clear_logs();
    do_read(16'h0923, "R1 conflict read data");
    check("R7 writeback beat count", wr_log.size(), 16);
    bad = 0;
    for (int i = 0; i < wr_log.size(); i++) if (wr_log[i] != 16'h0120 + 16'(i)) bad++;
    check("R7 writeback order", bad, 0);
    check("R7 written word", memval(16'h0125), 16'hBEEF);
    check("R1 fetch after writeback", (rd_log.size() > 0) ? rd_log[0] : 16'hFFFF, 16'h0920);

    // R7: clean victim
    clear_logs();
    do_read(16'h0125, "R7 reload data");
    check("R7 clean victim no writeback", wr_log.size(), 0);

    // R6: write miss
    clear_logs();
    do_write(16'h1045, 16'h1234);
    check("R6 write miss fills", rd_log.size(), 16);
    check("R6 fill base", (rd_log.size() > 0) ? rd_log[0] : 16'hFFFF, 16'h1040);
    check("R6 no memory write", wr_log.size(), 0);
    check("R6 memory untouched", memval(16'h1045), base_val(16'h1045));
    clear_logs();
    do_read(16'h1045, "R6 write miss readback");
    check("R6 readback is hit", rd_log.size(), 0);

    // R8: invalidate a resident modified block
    ext_update(16'h1045, 16'h7777);
    clear_logs();
    do_read(16'h1045, "R8 invalidated read data");
    check("R8 refetch after invalidate", rd_log.size(), 16);
    check("R8 modified data discarded", wr_log.size(), 0);

    // R8: invalidate of a non-resident block changes nothing
    @(negedge clk); inv_en = 1'b1; inv_addr = 16'h3123;
    @(negedge clk); inv_en = 1'b0;
    clear_logs();
    do_read(16'h0121, "R8 unrelated line data");
    check("R8 unrelated line still resident", rd_log.size(), 0);

    // R11: flush
    do_write(16'h0200, 16'h1111);
    do_write(16'h0310, 16'h2222);
    clear_logs();
    @(negedge clk); flush_req = 1'b1;
    @(posedge clk);
    @(negedge clk); flush_req = 1'b0;
    check("R10 ready low during flush", cpu_ready, 0);
    while (!cpu_ready) @(negedge clk);
    check("R11 flush beat count", wr_log.size(), 32);
    check("R11 flush first line", (wr_log.size() > 0) ? wr_log[0] : 16'hFFFF, 16'h0200);
    check("R11 flush second line", (wr_log.size() > 16) ? wr_log[16] : 16'hFFFF, 16'h0310);
    check("R11 flushed data", memval(16'h0200), 16'h1111);
    clear_logs();
    do_read(16'h2200, "R11 post-flush read");
    check("R11 dirty flag cleared", wr_log.size(), 0);

    // R1: seeded random traffic on colliding lines
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(2);
      a = {5'($urandom_range(3)), (sel == 0) ? 7'h12 : (sel == 1) ? 7'h13 : 7'h20,
           4'($urandom_range(15))};
      if ($urandom_range(19) == 0) ext_update(a, 16'($urandom));
      else if ($urandom_range(9) < 4) do_write(a, 16'($urandom));
      else do_read(a, "R1 random read");
    end

    report();
    $finish;
  end
endmodule